// File: doc/BRIEF.md
# Core Power-Up/Down Sequencer

This block steps the reset lines and the power-gate bit of one core in a four-core cluster through a safe power-up or power-down. A command names the core, says whether it is the small or the large core type, and picks the standard or the alternate gate-bit layout. The block then walks through a fixed series of steps. Each step changes one set of outputs and may wait a timed interval or wait for the external power-switch sequencer to finish. A one-cycle done pulse marks the end of each sequence.

Every reset output is active low, so a 0 holds that reset and a 1 releases it. The L1 reset-disable outputs are plain levels, and power-up drives them low for the small core type. The power-gate vector has one bit per core plus one extra bit, and a set bit means the power is gated off. Timed waits are counted in microsecond ticks made from a cycles-per-microsecond parameter. The power switch is opened or closed through a request/done handshake. Cluster-level sequencing and the register interface that issues the commands belong to other blocks.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset, all reset outputs (`por_n`, `por_alt_n`, `dbg_rst_n`, `trc_rst_n`, `core_rst_n`, `neon_rst_n`) are 0, `l1_rstdis` is all ones, `pwr_gate` is all ones, and `sw_req`, `busy`, `done` and `err` are 0.
- R2: On power-up, `por_n` of the selected core goes low first. The next step drives debug reset low, and for the small core type (`core_big`=0) also drives trace reset and L1 reset-disable low. The next step raises `sw_req` with `sw_open`=1. On the standard layout, `sw_req` rises 4 cycles after the command is sampled. `sw_req` stays high until `sw_done` is seen and drops in the cycle after.
- R3: The core's gate bit clears 2 cycles after `sw_done` is sampled. `por_n` of that core rises exactly GATE_US*US_CYC+1 cycles after the gate bit clears.
- R4: In the first step after power-on reset is released (and after its extra wait on the alternate layout), debug reset and core reset are released together. One cycle later, trace reset is released for the small core type or NEON reset for the large type, and `done` pulses in that same cycle. The large core type leaves trace reset and L1 reset-disable untouched.
- R5: With `alt_map`=1, `por_alt_n` of the core falls together with `por_n` and rises together with `por_n`. Each of those two steps is followed by a wait of ALT_US*US_CYC cycles. So `sw_req` rises ALT_US*US_CYC+4 cycles after the command, and debug release comes ALT_US*US_CYC+1 cycles after `por_n` rises. With `alt_map`=0, `por_alt_n` is not touched.
- R6: The gate bit is bit `core_sel`, except that core 0 with `alt_map`=1 uses bit 4 (bit NCORE). Each sequence changes only that one gate bit.
- R7: Power-down sets the core's gate bit 2 cycles after the command. `sw_req` rises with `sw_open`=0 exactly GATE_US*US_CYC+1 cycles after that. `done` pulses 2 cycles after `sw_done` is sampled, and no reset output changes.
- R8: A command with `core_sel` of 4 or more raises `err` for exactly one cycle in the next cycle, does not set `busy`, and changes no other output.
- R9: Commands that arrive while `busy` is high are ignored. If `start_up` and `start_down` are both high in the same idle cycle, power-up is performed.
- R10: `done` is a single-cycle pulse, given exactly once per accepted sequence, while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_up | input | 1 | Power-up command, sampled when idle |
| start_down | input | 1 | Power-down command, sampled when idle |
| core_sel | input | 3 | Target core index; 4 and above are rejected |
| core_big | input | 1 | 1 = large core type, 0 = small core type |
| alt_map | input | 1 | 1 = alternate layout (extra reset copy, core 0 gate on bit 4) |
| sw_done | input | 1 | Power switch sequencer finished the request |
| sw_req | output | 1 | Request to the power switch sequencer |
| sw_open | output | 1 | Request direction: 1 open, 0 close |
| por_n | output | 4 | Per-core power-on reset, active low |
| por_alt_n | output | 4 | Per-core second power-on reset copy, active low |
| dbg_rst_n | output | 4 | Per-core debug reset, active low |
| trc_rst_n | output | 4 | Per-core trace reset, active low |
| core_rst_n | output | 4 | Per-core core reset, active low |
| neon_rst_n | output | 4 | Per-core vector unit reset, active low |
| l1_rstdis | output | 4 | Per-core L1 reset-disable level |
| pwr_gate | output | 5 | Power-gate bits, 1 = gated |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err | output | 1 | One-cycle pulse on a rejected command |

## Verification
Every step is a registered state, and its outputs appear one cycle after the state is entered. Commands sampled at an edge therefore show their first effect two cycles later. A timed wait adds its length in cycles plus one, and a switch completion shows its effect two cycles after `sw_done` is sampled. The bench drives inputs and samples outputs on the falling edge, and stamps every output transition with a cycle count. It then compares the gaps between transitions with these exact figures. Waits are counted from the gate or reset change, never from the request, so the random delay in the modelled switch cannot shift an expected value.

// File: rtl/core_pwr_pkg.sv
`timescale 1ns/1ps
package core_pwr_pkg;

    // Sequencer steps; each step's output changes land on the edge that leaves it
    typedef enum logic [3:0] {
        S_IDLE,
        S_UP_POR,
        S_UP_PREP,
        S_UP_SW,
        S_UP_GATE,
        S_UP_POREL,
        S_UP_REL1,
        S_UP_REL2,
        S_DN_GATE,
        S_DN_SW,
        S_WAIT_T,
        S_WAIT_SW,
        S_FIN
    } cps_state_e;

endpackage

// File: rtl/cps_us_timer.sv
`timescale 1ns/1ps
module cps_us_timer #(
    parameter int US_CYC = 250,
    parameter int LEN_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LEN_W-1:0] len,
    output logic             expire
);
    localparam int PRE_W = (US_CYC > 1) ? $clog2(US_CYC) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(US_CYC - 1);

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] pre;
        logic [LEN_W-1:0] left;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d      = q;
        expire = q.run && (q.pre == '0) && (q.left == LEN_W'(1));
        if (go) begin
            d.run  = (len != '0);
            d.pre  = PRE_TOP;
            d.left = len;
        end else if (q.run) begin
            if (q.pre == '0) begin
                d.pre = PRE_TOP;
                if (q.left == LEN_W'(1)) d.run = 1'b0;
                else                     d.left = q.left - LEN_W'(1);
            end else begin
                d.pre = q.pre - PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/cps_gate_map.sv
`timescale 1ns/1ps
module cps_gate_map #(
    parameter int NCORE = 4,
    parameter int CW    = 2
) (
    input  logic [CW-1:0] idx,
    input  logic          alt,
    output logic [NCORE:0] mask
);
    // Per-core gate bits; core 0 moves to the spare top bit on the alternate layout
    for (genvar g = 0; g < NCORE; g++) begin : g_bit
        if (g == 0) begin : g_zero
            assign mask[g] = (idx == CW'(0)) && !alt;
        end else begin : g_other
            assign mask[g] = (idx == CW'(g));
        end
    end
    assign mask[NCORE] = alt && (idx == CW'(0));

endmodule

// File: rtl/core_pwr_seq.sv
`timescale 1ns/1ps
module core_pwr_seq
    import core_pwr_pkg::*;
#(
    parameter int NCORE   = 4,
    parameter int SEL_W   = 3,
    parameter int US_CYC  = 250,
    parameter int GATE_US = 20,
    parameter int ALT_US  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_up,
    input  logic             start_down,
    input  logic [SEL_W-1:0] core_sel,
    input  logic             core_big,
    input  logic             alt_map,
    input  logic             sw_done,
    output logic             sw_req,
    output logic             sw_open,
    output logic [NCORE-1:0] por_n,
    output logic [NCORE-1:0] por_alt_n,
    output logic [NCORE-1:0] dbg_rst_n,
    output logic [NCORE-1:0] trc_rst_n,
    output logic [NCORE-1:0] core_rst_n,
    output logic [NCORE-1:0] neon_rst_n,
    output logic [NCORE-1:0] l1_rstdis,
    output logic [NCORE:0]   pwr_gate,
    output logic             busy,
    output logic             done,
    output logic             err
);
    localparam int CW     = (NCORE > 1) ? $clog2(NCORE) : 1;
    localparam int MAX_US = (GATE_US > ALT_US) ? GATE_US : ALT_US;
    localparam int LEN_W  = $clog2(MAX_US + 1);

    typedef struct packed {
        cps_state_e       st;
        cps_state_e       ret;
        logic [CW-1:0]    idx;
        logic             big;
        logic             alt;
        logic [NCORE-1:0] por_n;
        logic [NCORE-1:0] por_alt_n;
        logic [NCORE-1:0] dbg_n;
        logic [NCORE-1:0] trc_n;
        logic [NCORE-1:0] core_n;
        logic [NCORE-1:0] neon_n;
        logic [NCORE-1:0] l1_dis;
        logic [NCORE:0]   gate;
        logic             sw_req;
        logic             sw_open;
        logic             done;
        logic             err;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st: S_IDLE, ret: S_IDLE, idx: '0, big: 1'b0, alt: 1'b0,
        por_n: '0, por_alt_n: '0, dbg_n: '0, trc_n: '0, core_n: '0,
        neon_n: '0, l1_dis: '1, gate: '1,
        sw_req: 1'b0, sw_open: 1'b0, done: 1'b0, err: 1'b0
    };

    seq_t q, d;

    logic             tmr_go;
    logic [LEN_W-1:0] tmr_len;
    logic             tmr_exp;
    logic [NCORE:0]   gmask;

    cps_us_timer #(
        .US_CYC (US_CYC),
        .LEN_W  (LEN_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (tmr_go),
        .len    (tmr_len),
        .expire (tmr_exp)
    );

    cps_gate_map #(
        .NCORE (NCORE),
        .CW    (CW)
    ) u_gmap (
        .idx  (q.idx),
        .alt  (q.alt),
        .mask (gmask)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.err   = 1'b0;
        tmr_go  = 1'b0;
        tmr_len = LEN_W'(GATE_US);
        case (q.st)
            S_IDLE: begin
                if (start_up || start_down) begin
                    if (core_sel > SEL_W'(NCORE - 1)) begin
                        d.err = 1'b1;
                    end else begin
                        d.idx = core_sel[CW-1:0];
                        d.big = core_big;
                        d.alt = alt_map;
                        d.st  = start_up ? S_UP_POR : S_DN_GATE;
                    end
                end
            end
            S_UP_POR: begin
                d.por_n[q.idx] = 1'b0;
                if (q.alt) begin
                    d.por_alt_n[q.idx] = 1'b0;
                    tmr_go  = 1'b1;
                    tmr_len = LEN_W'(ALT_US);
                    d.st    = S_WAIT_T;
                    d.ret   = S_UP_PREP;
                end else begin
                    d.st = S_UP_PREP;
                end
            end
            S_UP_PREP: begin
                d.dbg_n[q.idx] = 1'b0;
                if (!q.big) begin
                    d.l1_dis[q.idx] = 1'b0;
                    d.trc_n[q.idx]  = 1'b0;
                end
                d.st = S_UP_SW;
            end
            S_UP_SW: begin
                d.sw_req  = 1'b1;
                d.sw_open = 1'b1;
                d.st      = S_WAIT_SW;
                d.ret     = S_UP_GATE;
            end
            S_UP_GATE: begin
                d.gate = q.gate & ~gmask;
                tmr_go = 1'b1;
                d.st   = S_WAIT_T;
                d.ret  = S_UP_POREL;
            end
            S_UP_POREL: begin
                d.por_n[q.idx] = 1'b1;
                if (q.alt) begin
                    d.por_alt_n[q.idx] = 1'b1;
                    tmr_go  = 1'b1;
                    tmr_len = LEN_W'(ALT_US);
                    d.st    = S_WAIT_T;
                    d.ret   = S_UP_REL1;
                end else begin
                    d.st = S_UP_REL1;
                end
            end
            S_UP_REL1: begin
                d.dbg_n[q.idx]  = 1'b1;
                d.core_n[q.idx] = 1'b1;
                d.st            = S_UP_REL2;
            end
            S_UP_REL2: begin
                if (q.big) d.neon_n[q.idx] = 1'b1;
                else       d.trc_n[q.idx]  = 1'b1;
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
            S_DN_GATE: begin
                d.gate = q.gate | gmask;
                tmr_go = 1'b1;
                d.st   = S_WAIT_T;
                d.ret  = S_DN_SW;
            end
            S_DN_SW: begin
                d.sw_req  = 1'b1;
                d.sw_open = 1'b0;
                d.st      = S_WAIT_SW;
                d.ret     = S_FIN;
            end
            S_WAIT_T: begin
                if (tmr_exp) d.st = q.ret;
            end
            S_WAIT_SW: begin
                if (sw_done) begin
                    d.sw_req = 1'b0;
                    d.st     = q.ret;
                end
            end
            S_FIN: begin
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign sw_req     = q.sw_req;
    assign sw_open    = q.sw_open;
    assign por_n      = q.por_n;
    assign por_alt_n  = q.por_alt_n;
    assign dbg_rst_n  = q.dbg_n;
    assign trc_rst_n  = q.trc_n;
    assign core_rst_n = q.core_n;
    assign neon_rst_n = q.neon_n;
    assign l1_rstdis  = q.l1_dis;
    assign pwr_gate   = q.gate;
    assign busy       = (q.st != S_IDLE);
    assign done       = q.done;
    assign err        = q.err;

endmodule

// File: rtl/core_pwr_seq_chk.sv
`timescale 1ns/1ps
module core_pwr_seq_chk #(
    parameter int NCORE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_req,
    input logic             sw_done,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [NCORE-1:0] por_n,
    input logic [NCORE:0]   pwr_gate
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !sw_done) |=> sw_req); // R2
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && sw_done) |=> !sw_req); // R2
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy); // R8
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_GATE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pwr_gate ^ $past(pwr_gate)) <= 1); // R6
    for (genvar j = 0; j < NCORE; j++) begin : g_por
        AST_POR_HELD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pwr_gate[j]) |-> !por_n[j]); // R3
    end
    AST_POR_HELD_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_gate[NCORE]) |-> !por_n[0]); // R6

endmodule

bind core_pwr_seq core_pwr_seq_chk #(.NCORE(NCORE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_req   (sw_req),
    .sw_done  (sw_done),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .por_n    (por_n),
    .pwr_gate (pwr_gate)
);

// File: tb/core_pwr_seq_bench.sv
`timescale 1ns/1ps
module core_pwr_seq_bench;
    localparam int NC = 4;
    localparam int UC = 2;
    localparam int GU = 20;
    localparam int AU = 10;
    localparam int N  = GU * UC;
    localparam int M  = AU * UC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_up = 1'b0, start_down = 1'b0;
    logic [2:0] core_sel = '0;
    logic       core_big = 1'b0, alt_map = 1'b0;
    logic       sw_done = 1'b0;
    logic       sw_req, sw_open, busy, done, err;
    logic [3:0] por_n, por_alt_n, dbg_rst_n, trc_rst_n, core_rst_n, neon_rst_n, l1_rstdis;
    logic [4:0] pwr_gate;

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;

    logic [3:0] m_por, m_alt, m_dbg, m_trc, m_core, m_neon, m_l1;
    logic [4:0] m_gate;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    core_pwr_seq #(
        .NCORE(NC), .SEL_W(3), .US_CYC(UC), .GATE_US(GU), .ALT_US(AU)
    ) u_core_pwr_seq (
        .clk(clk), .rst_n(rst_n), .start_up(start_up), .start_down(start_down),
        .core_sel(core_sel), .core_big(core_big), .alt_map(alt_map),
        .sw_done(sw_done), .sw_req(sw_req), .sw_open(sw_open),
        .por_n(por_n), .por_alt_n(por_alt_n), .dbg_rst_n(dbg_rst_n),
        .trc_rst_n(trc_rst_n), .core_rst_n(core_rst_n), .neon_rst_n(neon_rst_n),
        .l1_rstdis(l1_rstdis), .pwr_gate(pwr_gate), .busy(busy), .done(done), .err(err)
    );

    // Power switch partner: answers each request after a random delay
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sw_req) begin
                int dl;
                dl = $urandom_range(0, 3);
                repeat (dl) begin @(posedge clk); #1; end
                sw_done = 1'b1;
                @(posedge clk);
                #1;
                sw_done = 1'b0;
            end
        end
    end

    function automatic int gbit(int i, bit alt);
        return (alt && i == 0) ? NC : i;
    endfunction

    task automatic chk_eq(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_model(string req);
        chk_eq(req, "por_n", int'(por_n), int'(m_por));
        chk_eq(req, "por_alt_n", int'(por_alt_n), int'(m_alt));
        chk_eq(req, "dbg_rst_n", int'(dbg_rst_n), int'(m_dbg));
        chk_eq(req, "trc_rst_n", int'(trc_rst_n), int'(m_trc));
        chk_eq(req, "core_rst_n", int'(core_rst_n), int'(m_core));
        chk_eq(req, "neon_rst_n", int'(neon_rst_n), int'(m_neon));
        chk_eq(req, "l1_rstdis", int'(l1_rstdis), int'(m_l1));
        chk_eq(req, "pwr_gate", int'(pwr_gate), int'(m_gate));
        chk_eq(req, "idle flags", int'({busy, sw_req, done, err}), 0);
    endtask

    task automatic run_up(int i, bit big, bit alt, bit both, bit poke);
        int s, t_req, t_swd, t_gclr, t_porr, t_dbgr, t_done, ndone, b;
        logic [3:0] p_por, p_dbg;
        logic [4:0] p_gate;
        logic       p_req;
        string      rq;
        b = gbit(i, alt);
        rq = alt ? "R5" : "R2";
        t_req = -1; t_swd = -1; t_gclr = -1; t_porr = -1; t_dbgr = -1; t_done = -1; ndone = 0;
        @(negedge clk);
        start_up = 1'b1; start_down = both; core_sel = 3'(i); core_big = big; alt_map = alt;
        s = cyc;
        p_por = por_n; p_dbg = dbg_rst_n; p_gate = pwr_gate; p_req = sw_req;
        @(negedge clk);
        start_up = 1'b0; start_down = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            if (poke && cyc == s + 3) begin
                start_up = 1'b1; start_down = 1'b1; core_sel = 3'((i + 1) % NC);
            end else begin
                start_up = 1'b0; start_down = 1'b0; core_sel = 3'(i);
            end
            if (sw_req && !p_req) begin
                t_req = cyc;
                chk_eq(rq, "por_n low at switch request", int'(por_n[i]), 0);
                chk_eq(rq, "debug reset low at switch request", int'(dbg_rst_n[i]), 0);
                chk_eq("R9", "open direction (up wins)", int'(sw_open), 1);
                chk_eq("R9", "busy during sequence", int'(busy), 1);
                chk_eq("R5", "por_alt_n at switch request", int'(por_alt_n[i]), alt ? 0 : int'(m_alt[i]));
                if (!big) begin
                    chk_eq("R2", "trace reset low (small)", int'(trc_rst_n[i]), 0);
                    chk_eq("R2", "l1 reset-disable low (small)", int'(l1_rstdis[i]), 0);
                end else begin
                    chk_eq("R4", "trace reset untouched (big)", int'(trc_rst_n[i]), int'(m_trc[i]));
                    chk_eq("R4", "l1 untouched (big)", int'(l1_rstdis[i]), int'(m_l1[i]));
                end
                chk_eq("R3", "gate still set at request", int'(pwr_gate[b]), 1);
            end
            if (sw_done && t_swd < 0) t_swd = cyc;
            if (!pwr_gate[b] && p_gate[b]) t_gclr = cyc;
            if (por_n[i] && !p_por[i]) begin
                t_porr = cyc;
                chk_eq("R4", "debug reset still held at por release", int'(dbg_rst_n[i]), 0);
                if (alt) chk_eq("R5", "por_alt_n rises with por_n", int'(por_alt_n[i]), 1);
            end
            if (dbg_rst_n[i] && !p_dbg[i]) begin
                t_dbgr = cyc;
                chk_eq("R4", "core reset released with debug", int'(core_rst_n[i]), 1);
                if (!big) chk_eq("R4", "trace reset still held", int'(trc_rst_n[i]), 0);
            end
            if (done) begin
                ndone++;
                if (t_done < 0) begin
                    t_done = cyc;
                    if (big) chk_eq("R4", "neon released at done", int'(neon_rst_n[i]), 1);
                    else     chk_eq("R4", "trace released at done", int'(trc_rst_n[i]), 1);
                end
            end
            p_por = por_n; p_dbg = dbg_rst_n; p_gate = pwr_gate; p_req = sw_req;
            if (t_done >= 0 && cyc >= t_done + 6) break;
            @(negedge clk);
        end
        start_up = 1'b0; start_down = 1'b0;
        chk_eq(rq, "command to switch request", t_req - s, alt ? M + 4 : 4);
        chk_eq("R3", "switch done to gate clear", t_gclr - t_swd, 2);
        chk_eq("R3", "gate clear to por release", t_porr - t_gclr, N + 1);
        chk_eq(alt ? "R5" : "R4", "por release to debug release", t_dbgr - t_porr, alt ? M + 1 : 1);
        chk_eq("R4", "debug release to done", t_done - t_dbgr, 1);
        chk_eq("R10", "done pulses per sequence", ndone, 1);
        m_por[i] = 1'b1; m_dbg[i] = 1'b1; m_core[i] = 1'b1;
        if (alt) m_alt[i] = 1'b1;
        if (big) m_neon[i] = 1'b1;
        else begin m_trc[i] = 1'b1; m_l1[i] = 1'b0; end
        m_gate[b] = 1'b0;
        check_model(poke ? "R9" : "R6");
    endtask

    task automatic run_down(int i, bit alt);
        int s, t_gset, t_req, t_swd, t_done, ndone, b;
        logic [4:0] p_gate;
        logic       p_req;
        b = gbit(i, alt);
        t_gset = -1; t_req = -1; t_swd = -1; t_done = -1; ndone = 0;
        @(negedge clk);
        start_down = 1'b1; core_sel = 3'(i); alt_map = alt; core_big = $urandom_range(0, 1);
        s = cyc;
        p_gate = pwr_gate; p_req = sw_req;
        @(negedge clk);
        start_down = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            if (pwr_gate[b] && !p_gate[b]) t_gset = cyc;
            if (sw_req && !p_req) begin
                t_req = cyc;
                chk_eq("R7", "close direction", int'(sw_open), 0);
            end
            if (sw_done && t_swd < 0) t_swd = cyc;
            if (done) begin ndone++; if (t_done < 0) t_done = cyc; end
            p_gate = pwr_gate; p_req = sw_req;
            if (t_done >= 0 && cyc >= t_done + 6) break;
            @(negedge clk);
        end
        chk_eq("R7", "command to gate set", t_gset - s, 2);
        chk_eq("R7", "gate set to switch request", t_req - t_gset, N + 1);
        chk_eq("R7", "switch done to done", t_done - t_swd, 2);
        chk_eq("R10", "done pulses per sequence", ndone, 1);
        m_gate[b] = 1'b1;
        check_model("R7");
    endtask

    task automatic run_err(int sel);
        @(negedge clk);
        start_up = 1'b1; core_sel = 3'(sel); alt_map = 1'b0;
        @(negedge clk);
        start_up = 1'b0;
        chk_eq("R8", "err pulse", int'(err), 1);
        chk_eq("R8", "busy on reject", int'(busy), 0);
        @(negedge clk);
        chk_eq("R8", "err cleared", int'(err), 0);
        repeat (4) begin
            @(negedge clk);
            chk_eq("R8", "no activity after reject", int'({busy, done, sw_req}), 0);
        end
        check_model("R8");
    endtask

    initial begin
        void'($urandom(32'd4242));
        m_por = '0; m_alt = '0; m_dbg = '0; m_trc = '0; m_core = '0; m_neon = '0;
        m_l1 = 4'hF; m_gate = 5'h1F;
        repeat (4) @(negedge clk);
        check_model("R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_model("R1");

        run_up(0, 1'b0, 1'b0, 1'b0, 1'b0);   // small core, standard layout
        run_up(1, 1'b1, 1'b1, 1'b0, 1'b0);   // big core, alternate layout
        run_up(0, 1'b0, 1'b1, 1'b0, 1'b0);   // core 0 on spare gate bit
        run_down(0, 1'b0);
        run_down(0, 1'b1);
        run_up(3, 1'b0, 1'b0, 1'b1, 1'b0);   // both commands at once
        run_up(2, 1'b1, 1'b0, 1'b0, 1'b1);   // commands while busy
        run_err(4);
        run_err(7);

        for (int r = 0; r < 16; r++) begin
            int  i;
            bit  a, bg, bo;
            i  = $urandom_range(0, NC - 1);
            a  = 1'($urandom_range(0, 1));
            bg = 1'($urandom_range(0, 1));
            bo = ($urandom_range(0, 3) == 0);
            if (m_gate[gbit(i, a)]) run_up(i, bg, a, bo, 1'b0);
            else                    run_down(i, a);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule